// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading translation descriptors from memory. A consumer hands it one virtual address at a time through a valid/ready request port. The walker reads one first-level descriptor from a table whose base is supplied on a dedicated input. Depending on that descriptor it either finishes or reads one second-level descriptor. It then presents the physical address and a fault flag on a valid/ready result port.

Four mapping granules are recognised: 16 MB, 1 MB, 64 KB and 4 KB. The 16 MB and 64 KB granules are stored by software as sixteen identical copies in consecutive slots. For that reason the walker only has to use a different split between descriptor bits and virtual-address bits when it forms the output. Only one translation is in flight at a time. The memory port uses a request/grant handshake followed by a separate read-data strobe, and any number of wait cycles may occur on either side.

Top module: `tt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `res_valid` and `mem_req` are 0.
- R2: A request is taken only when `req_ready` is 1. `req_ready` stays 0 from the cycle after acceptance until the result has been consumed, and a `req_valid` or `req_va` presented meanwhile does not change the result of the translation in flight.
- R3: The first memory read goes to address {`tbl_base`[17:0], VA[31:20], 2'b00}.
- R4: A first-level descriptor whose low two bits are 2'b00 or 2'b11 ends the walk after one read, with `res_fault`=1 and `res_pa`=0.
- R5: A first-level descriptor with low bits 2'b10 and bit 18 clear gives `res_pa` = {desc[31:20], VA[19:0]}, with no fault and no second read.
- R6: A first-level descriptor with low bits 2'b10 and bit 18 set gives `res_pa` = {desc[31:24], VA[23:0]}, with no fault and no second read.
- R7: A first-level descriptor with low bits 2'b01 causes a second read at address {desc[31:10], VA[19:12], 2'b00}.
- R8: A second-level descriptor with bit 1 set gives `res_pa` = {desc[31:12], VA[11:0]}, with no fault.
- R9: A second-level descriptor with low bits 2'b01 gives `res_pa` = {desc[31:16], VA[15:0]}, with no fault.
- R10: A second-level descriptor with low bits 2'b00 gives `res_fault`=1 and `res_pa`=0.
- R11: `mem_req` stays high with a constant `mem_addr` until a cycle with `mem_gnt` high, and any number of wait cycles before the grant or before `mem_rvalid` gives the same result.
- R12: `res_valid`, `res_pa` and `res_fault` hold their values until a cycle with `res_ready` high, after which `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base | input | 18 | First-level table physical base, shifted right by 14 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 32 | Translated physical address, zero on a fault |
| res_fault | output | 1 | Translation faulted |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_gnt | input | 1 | Memory accepts the read request |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Descriptor word |

## Verification
The assertions rely on the environment to behave in three ways. `mem_gnt` is raised only while `mem_req` is high. `mem_rvalid` arrives exactly once for each grant, and only after it. `tbl_base` does not change while a walk is in progress. The memory model in the bench serves one read at a time, raises the grant only after it has seen a request, and returns data a varying number of cycles later. The table base is fixed for the whole run. Descriptor contents are generated from the slot index, so the sweep covers every first-level slot and every kind of descriptor on both levels.

// File: rtl/walk_pkg.sv
// Shared types for the page table walker.
// Assumes: one walk in flight; encodings below are fixed by the table format.
package walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_L1,
        ST_WAIT_L1,
        ST_FETCH_L2,
        ST_WAIT_L2,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        L1K_FAULT,
        L1K_TABLE,
        L1K_LEAF
    } l1_kind_e;

    // Low-bit type codes of descriptors
    localparam logic [1:0] L1_TYPE_TABLE = 2'b01;
    localparam logic [1:0] L1_TYPE_SECT  = 2'b10;
    localparam logic [1:0] L2_TYPE_LARGE = 2'b01;

    // Bit of a section descriptor that selects the 16x replicated form
    localparam int SUPER_BIT = 18;
    // Replication factor of supersections and large pages, as address bits
    localparam int REPL_BITS = 4;

endpackage

// File: rtl/walk_l1_decode.sv
// First-level descriptor decoder.
// Classifies a descriptor as fault, table pointer or leaf. For a leaf it
// forms the final address (1 MB section or 16 MB supersection). For a
// pointer it extracts the second-level table base.
// Assumes: OFF_W is the section offset width; table bases are 1 KB aligned.
module walk_l1_decode
    import walk_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int OFF_W    = 20,
    parameter int L2_IDX_W = 8
) (
    input  logic [VA_W-1:0]             desc,
    input  logic [VA_W-1:0]             va,
    output l1_kind_e                    kind,
    output logic [VA_W-1:0]             leaf_pa,
    output logic [VA_W-L2_IDX_W-3:0]    l2_base
);
    localparam int SS_OFF_W = OFF_W + REPL_BITS;

    // Classify the descriptor and compose the leaf address
    always_comb begin
        kind    = L1K_FAULT;
        leaf_pa = '0;
        l2_base = desc[VA_W-1:L2_IDX_W+2];
        if (desc[1:0] == L1_TYPE_TABLE) begin
            kind = L1K_TABLE;
        end else if (desc[1:0] == L1_TYPE_SECT) begin
            kind = L1K_LEAF;
            if (desc[SUPER_BIT])
                leaf_pa = {desc[VA_W-1:SS_OFF_W], va[SS_OFF_W-1:0]};
            else
                leaf_pa = {desc[VA_W-1:OFF_W], va[OFF_W-1:0]};
        end
    end

    // A fault leaves no address behind
    always_comb begin
        assert (kind != L1K_FAULT || leaf_pa == '0);
    end
endmodule

// File: rtl/walk_l2_decode.sv
// Second-level descriptor decoder.
// Forms the final address for a 4 KB small page or a 64 KB large page, or
// flags a fault with a zero address.
// Assumes: PAGE_W is the small-page offset width.
module walk_l2_decode
    import walk_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12
) (
    input  logic [VA_W-1:0] desc,
    input  logic [VA_W-1:0] va,
    output logic            fault,
    output logic [VA_W-1:0] pa
);
    localparam int LP_OFF_W = PAGE_W + REPL_BITS;

    // Select the granule from the type bits and compose the address
    always_comb begin
        fault = 1'b0;
        pa    = '0;
        if (desc[1]) begin
            pa = {desc[VA_W-1:PAGE_W], va[PAGE_W-1:0]};
        end else if (desc[1:0] == L2_TYPE_LARGE) begin
            pa = {desc[VA_W-1:LP_OFF_W], va[LP_OFF_W-1:0]};
        end else begin
            fault = 1'b1;
        end
    end
endmodule

// File: rtl/tt_walker.sv
// Two-level page table walker, top level.
// Accepts one virtual address, reads one or two descriptors over a
// request/grant + read-data port, and holds the result until consumed.
// Assumes: mem_gnt only while mem_req; exactly one mem_rvalid per grant,
// after it; tbl_base stable during a walk; L1 index and L2 index plus page
// offset tile the virtual address.
module tt_walker
    import walk_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8,
    parameter int PAGE_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [VA_W-L1_IDX_W-3:0]    tbl_base,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [VA_W-1:0]             req_va,
    output logic                        res_valid,
    input  logic                        res_ready,
    output logic [VA_W-1:0]             res_pa,
    output logic                        res_fault,
    output logic                        mem_req,
    output logic [VA_W-1:0]             mem_addr,
    input  logic                        mem_gnt,
    input  logic                        mem_rvalid,
    input  logic [VA_W-1:0]             mem_rdata
);
    localparam int OFF_W   = VA_W - L1_IDX_W;
    localparam int L2B_W   = VA_W - L2_IDX_W - 2;

    walk_state_e            state_q;
    logic [VA_W-1:0]        va_q;
    logic [L2B_W-1:0]       l2_base_q;
    logic [VA_W-1:0]        pa_q;
    logic                   fault_q;

    l1_kind_e               l1_kind;
    logic [VA_W-1:0]        l1_pa;
    logic [L2B_W-1:0]       l1_next;
    logic                   l2_fault;
    logic [VA_W-1:0]        l2_pa;

    walk_l1_decode #(.VA_W(VA_W), .OFF_W(OFF_W), .L2_IDX_W(L2_IDX_W)) i_l1 (
        .desc(mem_rdata), .va(va_q), .kind(l1_kind),
        .leaf_pa(l1_pa), .l2_base(l1_next)
    );

    walk_l2_decode #(.VA_W(VA_W), .PAGE_W(PAGE_W)) i_l2 (
        .desc(mem_rdata), .va(va_q), .fault(l2_fault), .pa(l2_pa)
    );

    // Sequence the walk: accept, fetch level 1, maybe level 2, hold result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            va_q      <= '0;
            l2_base_q <= '0;
            pa_q      <= '0;
            fault_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    state_q <= ST_FETCH_L1;
                end
                ST_FETCH_L1: if (mem_gnt) state_q <= ST_WAIT_L1;
                ST_WAIT_L1: if (mem_rvalid) begin
                    unique case (l1_kind)
                        L1K_TABLE: begin
                            l2_base_q <= l1_next;
                            state_q   <= ST_FETCH_L2;
                        end
                        L1K_LEAF: begin
                            pa_q    <= l1_pa;
                            fault_q <= 1'b0;
                            state_q <= ST_DONE;
                        end
                        default: begin
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    endcase
                end
                ST_FETCH_L2: if (mem_gnt) state_q <= ST_WAIT_L2;
                ST_WAIT_L2: if (mem_rvalid) begin
                    pa_q    <= l2_pa;
                    fault_q <= l2_fault;
                    state_q <= ST_DONE;
                end
                ST_DONE: if (res_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the descriptor address for whichever level is being fetched
    always_comb begin
        mem_req  = (state_q == ST_FETCH_L1) || (state_q == ST_FETCH_L2);
        if (state_q == ST_FETCH_L2)
            mem_addr = {l2_base_q, va_q[PAGE_W+L2_IDX_W-1:PAGE_W], 2'b00};
        else
            mem_addr = {tbl_base, va_q[VA_W-1:OFF_W], 2'b00};
    end

    // Expose the handshakes and the held result
    assign req_ready = (state_q == ST_IDLE);
    assign res_valid = (state_q == ST_DONE);
    assign res_pa    = pa_q;
    assign res_fault = fault_q;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req && !req_ready));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    assert_res_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_pa) && $stable(res_fault)));

    assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_pa == '0));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (!mem_req && !res_valid));
endmodule

// File: tb/test_tt_walker.sv
module test_tt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] tbl_base = 18'h00003;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_pa;
    logic        res_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    int n_acc = 0;
    logic [31:0] acc_addr [2];
    int delay_ctr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tt_walker i_tt_walker (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
        .res_fault(res_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] l1d(input int i);
        case (i % 4)
            0: l1d = 32'h0;
            1: l1d = {22'(32'h40000 + i), 8'h00, 2'b01};
            2: l1d = {12'(i * 37 + 5), 1'b1, i[2], 16'h0, 2'b10};
            default: l1d = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] l2d(input int i, input int j);
        case ((i + j) % 4)
            0: l2d = 32'h0;
            1: l2d = {16'(i * 13 + j), 14'h0, 2'b01};
            2: l2d = {20'(i * 101 + j * 3), 10'h0, 2'b10};
            default: l2d = {20'(i * 101 + j * 3), 10'h0, 2'b11};
        endcase
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a[31:28] != 4'h0)
            mem_read = l2d(int'(a[21:10]), int'(a[9:2]));
        else if (a[31:14] == tbl_base)
            mem_read = l1d(int'(a[13:2]));
        else
            mem_read = 32'hDEAD_BEEF;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: grant and data after a varying number of wait cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [31:0] a0;
                a0 = mem_addr;
                repeat (delay_ctr % 3) begin
                    @(negedge clk);
                    chk(mem_req && mem_addr == a0, "R11 addr held", mem_addr, a0);
                end
                mem_gnt = 1'b1;
                if (n_acc < 2) acc_addr[n_acc] = mem_addr;
                n_acc++;
                @(negedge clk);
                mem_gnt = 1'b0;
                repeat ((delay_ctr / 3) % 4) @(negedge clk);
                delay_ctr++;
                mem_rvalid = 1'b1;
                mem_rdata = mem_read(a0);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata = '0;
            end
        end
    end

    task automatic run(input logic [31:0] va, input int hold, input bit poke);
        int i;
        int j;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [31:0] exp_pa;
        logic [31:0] l2a;
        bit exp_fault;
        int exp_acc;
        string tag;
        logic [31:0] pa0;
        i = int'(va[31:20]);
        j = int'(va[19:12]);
        while (!req_ready) @(negedge clk);
        n_acc = 0;
        req_va = va;
        req_valid = 1'b1;
        @(negedge clk);
        if (poke) req_va = ~va;
        else req_valid = 1'b0;
        while (!res_valid) begin
            if (poke) chk(!req_ready, "R2 busy not ready", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        d1 = l1d(i);
        exp_acc = 1;
        l2a = 32'h0;
        if (d1[1:0] == 2'b00 || d1[1:0] == 2'b11) begin
            exp_fault = 1; exp_pa = 0; tag = "R4";
        end else if (d1[1:0] == 2'b10) begin
            exp_fault = 0;
            if (d1[18]) begin exp_pa = {d1[31:24], va[23:0]}; tag = "R6"; end
            else begin exp_pa = {d1[31:20], va[19:0]}; tag = "R5"; end
        end else begin
            exp_acc = 2;
            l2a = {d1[31:10], va[19:12], 2'b00};
            d2 = l2d(i, j);
            if (d2[1]) begin exp_fault = 0; exp_pa = {d2[31:12], va[11:0]}; tag = "R8"; end
            else if (d2[1:0] == 2'b01) begin exp_fault = 0; exp_pa = {d2[31:16], va[15:0]}; tag = "R9"; end
            else begin exp_fault = 1; exp_pa = 0; tag = "R10"; end
        end
        if (poke) tag = {tag, " R2"};
        chk(res_pa == exp_pa, {tag, " pa"}, res_pa, exp_pa);
        chk(res_fault == exp_fault, {tag, " fault"}, 32'(res_fault), 32'(exp_fault));
        chk(n_acc == exp_acc, {tag, " read count"}, 32'(n_acc), 32'(exp_acc));
        chk(acc_addr[0] == {tbl_base, va[31:20], 2'b00}, "R3 L1 address",
            acc_addr[0], {tbl_base, va[31:20], 2'b00});
        if (exp_acc == 2)
            chk(acc_addr[1] == l2a, "R7 L2 address", acc_addr[1], l2a);
        pa0 = res_pa;
        repeat (hold) begin
            @(negedge clk);
            chk(res_valid && res_pa == pa0 && !req_ready, "R12 result held", res_pa, pa0);
        end
        res_ready = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        res_ready = 1'b0;
        chk(req_ready && !res_valid, "R12 back to idle", 32'(req_ready), 32'd1);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !res_valid && !mem_req, "R1 reset state",
            {29'd0, req_ready, res_valid, mem_req}, 32'h4);
        for (int k = 0; k < 4096; k++) begin
            logic [31:0] lo;
            lo = 32'(k * 40503 + 77);
            run({k[11:0], lo[19:0]}, k % 3, (k % 97) == 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule